// File: doc/BRIEF.md
# Dual-Rank Bidirectional Shift Register

This block pairs a bus-side holding register (the upper rank) with a serial shift register (the lower rank). Both ranks share one clock. The upper rank faces a bidirectional parallel port. That port is modelled as three separate vectors: a pin-input vector, a pin-output vector and a per-bit output-enable vector. The lower rank has a serial input and a serial output. Devices can be chained into longer words by feeding one instance's serial output into the next instance's serial input.

Five control inputs select the work done on each rising edge. All five are active low:
- `in_dis_n` enables port input.
- `out_dis_n` enables port drive.
- `up_dis_n` enables the upward transfer (lower to upper).
- `down_dis_n` enables the downward transfer (upper to lower).
- `shift_dis_n` enables the serial shift.

Several operations can happen in one edge. A port load combined with an upward transfer becomes an OR-merge. Particular combinations of the controls clear the ranks. Putting the port into high impedance does not hold back any internal operation.

A combinational decoder turns the four load controls into one named action per rank:
- Upper-rank actions: `A_HOLD`, `A_PIN`, `A_UP`, `A_MERGE`, `A_CLEAR`.
- Lower-rank actions: `B_HOLD`, `B_SHIFT`, `B_DOWN`, `B_CLEAR`.

Each rank register applies its action on the next rising edge. An action is in force only for the cycle in which it is decoded. The next edge always returns each rank to a freshly decoded action.

Top module: `dual_rank_shreg`

## Requirements
- R1: While `rst_n` is low, both ranks are zero. This makes `pin_out` all zeros and `ser_out` 0.
- R2: With port input enabled and upward transfer disabled (and not in the R8 combination), the upper rank takes `pin_in` on the edge.
- R3: With downward transfer enabled (and no clear combination), the lower rank takes the upper rank's value on the edge.
- R4: With upward transfer enabled and port input disabled, the upper rank takes the lower rank's value on the edge.
- R5: With shift enabled and downward transfer disabled, the lower rank shifts on the edge:
  - `ser_in` enters bit 0.
  - Bit i moves to bit i+1.
  - `ser_out` always shows bit W-1 of the lower rank.
- R6: With port input and upward transfer both enabled (and not R7 or R8), the upper rank takes `pin_in | lower rank`.
- R7: With port input, upward transfer and downward transfer enabled, and shift disabled, both ranks become zero on the edge.
- R8: With all four of port input, upward, downward and shift enabled, the upper rank takes `pin_in` and the lower rank becomes zero.
- R9: Downward transfer takes precedence over shift for the lower rank. Upward and downward transfers in the same edge (port input disabled) swap the two ranks.
- R10: With port input and upward transfer disabled, the upper rank holds. With shift and downward transfer disabled, the lower rank holds.
- R11: `pin_out` always carries the upper rank. `pin_oe` is all ones only when port drive is enabled and port input is disabled; otherwise it is all zeros. Input enable wins over drive enable.
- R12: Rank updates take place exactly as in R2 to R10, whether or not the port drive is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_dis_n | input | 1 | Active-low port drive enable |
| in_dis_n | input | 1 | Active-low port input enable |
| up_dis_n | input | 1 | Active-low lower-to-upper transfer enable |
| down_dis_n | input | 1 | Active-low upper-to-lower transfer enable |
| shift_dis_n | input | 1 | Active-low serial shift enable |
| ser_in | input | 1 | Serial data into bit 0 of the lower rank |
| pin_in | input | W | Value sensed on the parallel port |
| pin_out | output | W | Value offered to the parallel port (upper rank) |
| pin_oe | output | W | Per-bit port drive enable |
| ser_out | output | 1 | Bit W-1 of the lower rank |

## Verification
Rank changes are due one edge after the controls that request them:
- `pin_out` and `ser_out` reflect the new rank values in the same cycle as that edge.
- `pin_oe` follows the current controls with no clock delay.

The driver applies the controls on a falling edge and updates a requirement-based model at the following rising edge. It then queues the expected port values. The monitor samples 2 ns after that rising edge, before any new stimulus arrives.

The lower rank is not visible directly. Its contents reach the checks through `ser_out` and through later upward transfers, both of which the model follows cycle by cycle.

// File: rtl/dual_rank_pkg.sv
package dual_rank_pkg;

    typedef enum logic [2:0] {
        A_HOLD,
        A_PIN,
        A_UP,
        A_MERGE,
        A_CLEAR
    } upper_op_e;

    typedef enum logic [1:0] {
        B_HOLD,
        B_SHIFT,
        B_DOWN,
        B_CLEAR
    } lower_op_e;

endpackage

// File: rtl/dual_rank_decode.sv
module dual_rank_decode
    import dual_rank_pkg::*;
(
    input  logic      in_en,
    input  logic      up_en,
    input  logic      down_en,
    input  logic      shift_en,
    output upper_op_e a_op,
    output lower_op_e b_op
);

    logic [3:0] sel;
    assign sel = {in_en, up_en, down_en, shift_en};

    // Upper-rank action: clear and load-with-clear first, then merge, then single sources.
    always_comb begin
        priority casez (sel)
            4'b1110: a_op = A_CLEAR;
            4'b1111: a_op = A_PIN;
            4'b11??: a_op = A_MERGE;
            4'b10??: a_op = A_PIN;
            4'b01??: a_op = A_UP;
            default: a_op = A_HOLD;
        endcase
    end

    // Lower-rank action: clear combinations, then transfer down beats shift.
    always_comb begin
        priority casez (sel)
            4'b1110: b_op = B_CLEAR;
            4'b1111: b_op = B_CLEAR;
            4'b??1?: b_op = B_DOWN;
            4'b??01: b_op = B_SHIFT;
            default: b_op = B_HOLD;
        endcase
    end

endmodule

// File: rtl/dual_rank_upper.sv
module dual_rank_upper
    import dual_rank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  upper_op_e    op,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] lower_q,
    output logic [W-1:0] q
);

    logic [W-1:0] q_next;

    always_comb begin
        unique case (op)
            A_HOLD:  q_next = q;
            A_PIN:   q_next = pins;
            A_UP:    q_next = lower_q;
            A_MERGE: q_next = pins | lower_q;
            A_CLEAR: q_next = '0;
            default: q_next = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    AST_UPPER_PIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == A_PIN) |=> (q == $past(pins))); // R2

    AST_UPPER_TAKES_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (op == A_UP) |=> (q == $past(lower_q))); // R4

    AST_UPPER_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == A_MERGE) |=> (q == ($past(pins) | $past(lower_q)))); // R6

    AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == A_HOLD) |=> $stable(q)); // R10

endmodule

// File: rtl/dual_rank_lower.sv
module dual_rank_lower
    import dual_rank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  lower_op_e    op,
    input  logic         ser_in,
    input  logic [W-1:0] upper_q,
    output logic [W-1:0] q
);

    logic [W-1:0] q_next;

    always_comb begin
        unique case (op)
            B_HOLD:  q_next = q;
            B_SHIFT: q_next = {q[W-2:0], ser_in};
            B_DOWN:  q_next = upper_q;
            B_CLEAR: q_next = '0;
            default: q_next = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    AST_LOWER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == B_SHIFT) |=> (q[0] == $past(ser_in) && q[W-1:1] == $past(q[W-2:0]))); // R5

    AST_LOWER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (op == B_DOWN) |=> (q == $past(upper_q))); // R3

    AST_LOWER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == B_HOLD) |=> $stable(q)); // R10

endmodule

// File: rtl/dual_rank_shreg.sv
module dual_rank_shreg
    import dual_rank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         out_dis_n,
    input  logic         in_dis_n,
    input  logic         up_dis_n,
    input  logic         down_dis_n,
    input  logic         shift_dis_n,
    input  logic         ser_in,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic         ser_out
);

    localparam int MSB = W - 1;

    logic      in_en, out_en, up_en, down_en, shift_en;
    upper_op_e a_op;
    lower_op_e b_op;
    logic [W-1:0] a_q, b_q;

    assign in_en    = ~in_dis_n;
    assign out_en   = ~out_dis_n;
    assign up_en    = ~up_dis_n;
    assign down_en  = ~down_dis_n;
    assign shift_en = ~shift_dis_n;

    dual_rank_decode u_decode (
        .in_en    (in_en),
        .up_en    (up_en),
        .down_en  (down_en),
        .shift_en (shift_en),
        .a_op     (a_op),
        .b_op     (b_op)
    );

    dual_rank_upper #(.W(W)) u_upper (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (a_op),
        .pins    (pin_in),
        .lower_q (b_q),
        .q       (a_q)
    );

    dual_rank_lower #(.W(W)) u_lower (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (b_op),
        .ser_in  (ser_in),
        .upper_q (a_q),
        .q       (b_q)
    );

    // Port side: input enable dominates drive enable.
    always_comb begin
        pin_out = a_q;
        pin_oe  = (out_en && !in_en) ? {W{1'b1}} : {W{1'b0}};
        ser_out = b_q[MSB];
    end

    AST_INPUT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        in_en |-> (pin_oe == '0)); // R11

    AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_en && up_en && down_en && !shift_en) |=> (pin_out == '0 && ser_out == 1'b0)); // R7

    AST_LOAD_AND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_en && up_en && down_en && shift_en) |=> (pin_out == $past(pin_in) && ser_out == 1'b0)); // R8

    AST_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_en && up_en && down_en) |=> (a_q == $past(b_q) && b_q == $past(a_q))); // R9

    AST_SEROUT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (b_op == B_SHIFT) |=> (ser_out == $past(b_q[MSB-1]))); // R5

endmodule

// File: tb/dual_rank_shreg_test.sv
module dual_rank_shreg_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         out_dis_n = 1'b1, in_dis_n = 1'b1, up_dis_n = 1'b1;
    logic         down_dis_n = 1'b1, shift_dis_n = 1'b1, ser_in = 1'b0;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out, pin_oe;
    logic         ser_out;

    always #2.5 clk = ~clk;

    dual_rank_shreg #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .out_dis_n(out_dis_n), .in_dis_n(in_dis_n),
        .up_dis_n(up_dis_n), .down_dis_n(down_dis_n), .shift_dis_n(shift_dis_n),
        .ser_in(ser_in), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .ser_out(ser_out)
    );

    typedef struct {
        string        tag;
        logic [W-1:0] a;
        logic [W-1:0] oe;
        logic         so;
    } exp_t;

    exp_t         sb[$];
    int           total = 0, bad = 0;
    logic [W-1:0] a_m = '0, b_m = '0;
    bit           done = 1'b0;

    task automatic check(input string tag, input logic [W-1:0] a, input logic [W-1:0] oe, input logic so);
        total++;
        if (pin_out !== a || pin_oe !== oe || ser_out !== so) begin
            bad++;
            $display("FAIL %s: pin_out=%h pin_oe=%h ser_out=%b expected %h %h %b",
                     tag, pin_out, pin_oe, ser_out, a, oe, so);
        end
    endtask

    // Driver: apply controls at a falling edge, update model at the rising edge, queue expectation.
    task automatic step(input string tag, input bit ie, input bit up, input bit dn,
                        input bit sh, input bit oe, input bit si, input logic [W-1:0] pins);
        logic [W-1:0] na, nb, eoe;
        @(negedge clk);
        in_dis_n = ~ie; up_dis_n = ~up; down_dis_n = ~dn; shift_dis_n = ~sh;
        out_dis_n = ~oe; ser_in = si; pin_in = pins;
        if (ie && up && dn && !sh) begin
            na = '0; nb = '0;                       // R7
        end else if (ie && up && dn && sh) begin
            na = pins; nb = '0;                     // R8
        end else begin
            if (ie && up)  na = pins | b_m;         // R6
            else if (ie)   na = pins;               // R2
            else if (up)   na = b_m;                // R4
            else           na = a_m;                // R10
            if (dn)        nb = a_m;                // R3, R9
            else if (sh)   nb = {b_m[W-2:0], si};   // R5
            else           nb = b_m;                // R10
        end
        eoe = (oe && !ie) ? '1 : '0;                // R11
        @(posedge clk);
        a_m = na; b_m = nb;
        sb.push_back('{tag, na, eoe, nb[W-1]});
    endtask

    // Monitor: 2 ns after each rising edge, compare against the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, e.a, e.oe, e.so);
            end
        end
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        check("R1 reset", '0, '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        step("R10 idle hold",        0,0,0,0,0,0, 8'hFF);
        step("R2 R12 load hi-z",     1,0,0,0,0,0, 8'hA5);
        step("R10 hold A",           0,0,0,0,0,0, 8'h00);
        step("R11 input wins",       1,0,0,0,1,0, 8'h3C);
        step("R3 down",              0,0,1,0,0,0, 8'h00);
        step("R11 drive",            0,0,0,0,1,0, 8'h00);
        step("R5 shift 1",           0,0,0,1,0,1, 8'h00);
        step("R5 shift 2",           0,0,0,1,1,1, 8'h00);
        step("R5 shift 3",           0,0,0,1,0,0, 8'h00);
        step("R4 up",                0,1,0,0,1,0, 8'h00);
        step("R2 load with shift",   1,0,0,1,0,1, 8'h81);
        step("R6 merge",             1,1,0,0,0,0, 8'h0F);
        step("R6 merge with shift",  1,1,0,1,0,0, 8'h10);
        step("R9 swap",              0,1,1,0,0,0, 8'h00);
        step("R4 up check swap",     0,1,0,0,1,0, 8'h00);
        step("R2 load",              1,0,0,0,0,0, 8'h5A);
        step("R9 down beats shift",  0,0,1,1,0,1, 8'h00);
        step("R4 read B",            0,1,0,0,0,0, 8'h00);
        step("R8 load clear B",      1,1,1,1,0,0, 8'hC3);
        step("R8 B is zero",         0,1,0,0,1,0, 8'h00);
        step("R2 load",              1,0,0,0,0,0, 8'hE7);
        step("R3 down",              0,0,1,0,0,0, 8'h00);
        step("R7 clear",             1,1,1,0,1,0, 8'h99);
        step("R7 B cleared",         0,1,0,0,0,0, 8'h00);
        for (int i = 0; i < W + 2; i++)
            step("R5 cascade", 0,0,0,1,0,(i % 3 == 0), 8'h00);

        lf = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step("R12 mixed", lf[0], lf[1], lf[2], lf[3], lf[4], lf[5], lf[13:6]);
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule